// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order offset bits of a memory address during a short burst. When either of two active-low address strobes is seen on a rising clock edge, the low bits of the incoming address are captured as the burst start and the beat count returns to zero. Each later edge with the active-low advance input low steps the beat count by one. The offset driven to the memory array comes from the start value and the beat count.

A static strap selects how the beat count becomes an offset. With the strap low, the offset counts upward modulo the burst length (linear order). With the strap high, the offset is the start value XOR the beat count (interleaved order). After the last beat the sequence wraps back to the start value.

The upper address bits come from a separate register and pass straight through. They are joined with the offset to form the full address. There is no data path, so every pin is a plain control or address signal with no handshake.

Top module: `bseq_burst_addr`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the offset and the beat count both become 0 after that edge.
- R2: If `proc_strobe_n` or `ctrl_strobe_n` (or both) is low at a rising edge, then after that edge `burst_ofs` equals the value that `start_lo` held at the edge and `beat_idx` is 0.
- R3: If no strobe is low and `adv_n` is low at a rising edge, `beat_idx` increases by one modulo 2**OFS_W after that edge.
- R4: If no strobe is low and `adv_n` is high at a rising edge, `burst_ofs` and `beat_idx` keep their values.
- R5: A strobe and a low `adv_n` at the same edge reload the counter: the beat count becomes 0 and is not incremented.
- R6: With `mode_ilv` = 0 (linear), `burst_ofs` equals (start + beat_idx) mod 2**OFS_W. For example, start 3 gives 3,0,1,2.
- R7: With `mode_ilv` = 1 (interleaved), `burst_ofs` equals start XOR beat_idx. Start 1 gives 1,0,3,2 and start 2 gives 2,3,0,1.
- R8: After 2**OFS_W advances from a load, the offset is back at the loaded start value.
- R9: `full_addr` equals {`upper_addr`, `burst_ofs`}, with the upper part following `upper_addr` in the same cycle.
- R10: `mode_ilv` is a strap. It may change only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ilv | input | 1 | Order strap: 0 = linear, 1 = interleaved |
| proc_strobe_n | input | 1 | First address strobe, active low |
| ctrl_strobe_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| start_lo | input | OFS_W | Low address bits captured on a strobe |
| upper_addr | input | ADDR_W-OFS_W | Upper address bits from the external address register |
| burst_ofs | output | OFS_W | Current burst offset |
| beat_idx | output | OFS_W | Beats advanced since the last load |
| full_addr | output | ADDR_W | Upper bits joined with the offset |

## Verification
The bench uses the default parameters: ADDR_W = 16 and OFS_W = 2. A four-beat burst means a wrap back to the start is reached in four advances. Random traffic in both strap settings also covers all sixteen start and beat pairs. The 14-bit upper field is wide enough that pass-through errors in any bit position show up in the full address.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    EV_HOLD    = 2'd0,
    EV_ADVANCE = 2'd1,
    EV_RELOAD  = 2'd2
  } seq_event_e;

endpackage

// File: rtl/bseq_load_ctl.sv
module bseq_load_ctl
  import bseq_pkg::*;
(
  input  logic       proc_strobe_n,
  input  logic       ctrl_strobe_n,
  input  logic       adv_n,
  output seq_event_e ev
);

  logic strobe_seen;

  assign strobe_seen = ~proc_strobe_n | ~ctrl_strobe_n;

  // A strobe wins over advance.
  always_comb begin
    if (strobe_seen)  ev = EV_RELOAD;
    else if (!adv_n)  ev = EV_ADVANCE;
    else              ev = EV_HOLD;
  end

endmodule

// File: rtl/bseq_beat_reg.sv
module bseq_beat_reg
  import bseq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_event_e       ev,
  input  logic [OFS_W-1:0] start_lo,
  output logic [OFS_W-1:0] start_q,
  output logic [OFS_W-1:0] beat_q
);

  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      unique case (ev)
        EV_RELOAD: begin
          start_q <= start_lo;
          beat_q  <= '0;
        end
        EV_ADVANCE: beat_q <= beat_q + ONE;
        default: begin
          start_q <= start_q;
          beat_q  <= beat_q;
        end
      endcase
    end
  end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  order_e           order,
  input  logic [OFS_W-1:0] start_q,
  input  logic [OFS_W-1:0] beat_q,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  assign lin_ofs = start_q + beat_q;

  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv_bit
    assign ilv_ofs[b] = start_q[b] ^ beat_q[b];
  end

  assign ofs = (order == ORD_INTERLEAVED) ? ilv_ofs : lin_ofs;

endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_ilv,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    adv_n,
  input  logic [OFS_W-1:0]        start_lo,
  input  logic [ADDR_W-OFS_W-1:0] upper_addr,
  output logic [OFS_W-1:0]        burst_ofs,
  output logic [OFS_W-1:0]        beat_idx,
  output logic [ADDR_W-1:0]       full_addr
);

  localparam int UP_W = ADDR_W - OFS_W;

  seq_event_e       ev;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  order_e           order;

  assign order = order_e'(mode_ilv);

  bseq_load_ctl u_load_ctl (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .ev            (ev)
  );

  bseq_beat_reg #(.OFS_W(OFS_W)) u_beat_reg (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .start_lo (start_lo),
    .start_q  (start_q),
    .beat_q   (beat_q)
  );

  bseq_order_map #(.OFS_W(OFS_W)) u_order_map (
    .order   (order),
    .start_q (start_q),
    .beat_q  (beat_q),
    .ofs     (burst_ofs)
  );

  assign beat_idx                     = beat_q;
  assign full_addr[OFS_W-1:0]         = burst_ofs;
  assign full_addr[ADDR_W-1:OFS_W]    = upper_addr[UP_W-1:0];

endmodule

// File: rtl/bseq_burst_addr_chk.sv
module bseq_burst_addr_chk #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mode_ilv,
  input logic                    proc_strobe_n,
  input logic                    ctrl_strobe_n,
  input logic                    adv_n,
  input logic [OFS_W-1:0]        start_lo,
  input logic [OFS_W-1:0]        burst_ofs,
  input logic [OFS_W-1:0]        beat_idx
);

  logic stb;
  assign stb = ~proc_strobe_n | ~ctrl_strobe_n;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (burst_ofs == '0 && beat_idx == '0));

  // R2
  a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
    stb |=> (burst_ofs == $past(start_lo) && beat_idx == '0));

  // R3
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (!stb && !adv_n) |=> beat_idx == OFS_W'($past(beat_idx) + 1'b1));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!stb && adv_n) |=> ($stable(burst_ofs) && $stable(beat_idx)));

  // R5
  a_r5_strobe_wins: assert property (@(posedge clk) disable iff (rst)
    (stb && !adv_n) |=> beat_idx == '0);

  // R6
  a_r6_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!mode_ilv && !stb && !adv_n) |=> burst_ofs == OFS_W'($past(burst_ofs) + 1'b1));

  // R7
  a_r7_ilv_step: assert property (@(posedge clk) disable iff (rst)
    (mode_ilv && !stb && !adv_n) |=>
      burst_ofs == ($past(burst_ofs) ^ $past(beat_idx) ^ OFS_W'($past(beat_idx) + 1'b1)));

  // R10
  a_r10_strap_static: assert property (@(posedge clk) disable iff (rst)
    $stable(mode_ilv));

endmodule

bind bseq_burst_addr bseq_burst_addr_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_ilv      (mode_ilv),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .adv_n         (adv_n),
  .start_lo      (start_lo),
  .burst_ofs     (burst_ofs),
  .beat_idx      (beat_idx)
);

// File: tb/test_bseq_burst_addr.sv
module test_bseq_burst_addr;

  localparam int AW = 16;
  localparam int OW = 2;
  localparam int UW = AW - OW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_ilv = 1'b0;
  logic          pstb_n = 1'b1;
  logic          cstb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [OW-1:0] start_lo = '0;
  logic [UW-1:0] upper = '0;
  logic [OW-1:0] burst_ofs;
  logic [OW-1:0] beat_idx;
  logic [AW-1:0] full_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [OW-1:0] m_start = '0;
  logic [OW-1:0] m_beat = '0;

  always #10 clk = ~clk;

  bseq_burst_addr #(.ADDR_W(AW), .OFS_W(OW)) i_bseq_burst_addr (
    .clk           (clk),
    .rst           (rst),
    .mode_ilv      (mode_ilv),
    .proc_strobe_n (pstb_n),
    .ctrl_strobe_n (cstb_n),
    .adv_n         (adv_n),
    .start_lo      (start_lo),
    .upper_addr    (upper),
    .burst_ofs     (burst_ofs),
    .beat_idx      (beat_idx),
    .full_addr     (full_addr)
  );

  function automatic logic [OW-1:0] exp_ofs(logic [OW-1:0] s, logic [OW-1:0] b, logic ilv);
    return ilv ? (s ^ b) : OW'(s + b);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare 1 ns after it.
  task automatic cyc(logic p, logic c, logic a, logic [OW-1:0] lo, logic [UW-1:0] up);
    string ev_tag;
    pstb_n = p; cstb_n = c; adv_n = a; start_lo = lo; upper = up;
    @(posedge clk);
    if (rst) begin
      m_start = '0; m_beat = '0; ev_tag = "R1";
    end else if (!p || !c) begin
      m_start = lo; m_beat = '0; ev_tag = a ? "R2" : "R5";
    end else if (!a) begin
      m_beat = OW'(m_beat + 1'b1); ev_tag = "R3";
    end else begin
      ev_tag = "R4";
    end
    #1;
    chk({ev_tag, " beat"}, 32'(beat_idx), 32'(m_beat));
    chk(mode_ilv ? "R7 offset" : "R6 offset", 32'(burst_ofs), 32'(exp_ofs(m_start, m_beat, mode_ilv)));
    chk("R9 full address", 32'(full_addr), 32'({up, exp_ofs(m_start, m_beat, mode_ilv)}));
  endtask

  task automatic restart(logic ilv);
    rst = 1'b1;
    mode_ilv = ilv;   // R10: strap changes only under reset
    cyc(1, 1, 1, '0, '0);
    rst = 1'b0;
  endtask

  task automatic walk(logic ilv, logic [OW-1:0] s, logic [OW-1:0] e1, logic [OW-1:0] e2, logic [OW-1:0] e3);
    string t;
    t = ilv ? "R7 sequence" : "R6 sequence";
    cyc(0, 1, 1, s, 14'h1234);
    chk(t, 32'(burst_ofs), 32'(s));
    cyc(1, 1, 0, '0, 14'h1234); chk(t, 32'(burst_ofs), 32'(e1));
    cyc(1, 1, 0, '0, 14'h1234); chk(t, 32'(burst_ofs), 32'(e2));
    cyc(1, 1, 0, '0, 14'h1234); chk(t, 32'(burst_ofs), 32'(e3));
    cyc(1, 1, 0, '0, 14'h1234); chk("R8 wrap", 32'(burst_ofs), 32'(s));
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));

    // R1 reset state
    cyc(1, 1, 0, 2'd3, '0);
    cyc(1, 1, 1, 2'd1, '0);
    chk("R1 reset offset", 32'(burst_ofs), 32'd0);
    chk("R1 reset beat", 32'(beat_idx), 32'd0);
    rst = 1'b0;

    // R6 linear, start 3 -> 3,0,1,2 then wrap
    walk(1'b0, 2'd3, 2'd0, 2'd1, 2'd2);
    // R4 hold
    cyc(1, 1, 1, 2'd2, 14'h0abc);
    cyc(1, 1, 1, 2'd1, 14'h3fff);
    chk("R4 hold offset", 32'(burst_ofs), 32'd3);
    // R5 strobe beats advance, via second strobe
    cyc(1, 1, 0, '0, '0);
    cyc(1, 0, 0, 2'd2, 14'h2001);
    chk("R5 priority beat", 32'(beat_idx), 32'd0);
    chk("R5 priority offset", 32'(burst_ofs), 32'd2);
    // R2 both strobes together
    cyc(0, 0, 1, 2'd1, 14'h0001);
    chk("R2 both strobes", 32'(burst_ofs), 32'd1);

    // R7 interleaved sequences
    restart(1'b1);
    walk(1'b1, 2'd1, 2'd0, 2'd3, 2'd2);
    walk(1'b1, 2'd2, 2'd3, 2'd0, 2'd1);
    walk(1'b1, 2'd3, 2'd2, 2'd1, 2'd0);

    // Random traffic in both strap settings
    for (int m = 0; m < 2; m++) begin
      restart(m[0]);
      for (int i = 0; i < 600; i++) begin
        cyc(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 2) != 0,
            OW'($urandom), UW'($urandom));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule